// File: doc/BRIEF.md
# Grouped Pin-Toggle Interrupt Controller

This block watches 27 general-purpose input pins split into four groups of uneven size and raises one interrupt request per group. Every pin is brought into the clock domain through a synchronizer. A toggle on a pin is any difference between its synchronized value and the value sampled one cycle earlier, so a rise and a fall both count.

Two levels of enable decide whether a toggle is recorded. A per-pin mask selects pins inside a group, and a per-group enable bit sits in a shared control register. A recorded toggle sets the group's pending flag. A pending flag raises the group's request only while the group is enabled and the global interrupt enable input is high. Software reads and writes the control, flag and mask registers over a small synchronous register bus. The interrupt dispatcher clears a flag with a per-group acknowledge pulse, and software clears it by writing a one to it.

Top module: `pcint_groups`

## Requirements
- R1: After reset the control register, the flag register and every mask register read zero, and all requests are low.
- R2: Register addresses: 0 is control (bits 3:0 are the group enables, bits 7:4 always read zero), 1 is the flag register (bits 3:0), and 2 to 5 are the masks of groups 0 to 3. In a mask, bit i selects pin (8*group + i). Mask bits with no pin always read zero: bit 7 of group 1 and bits 7:3 of group 3. Addresses 6 and 7 read zero.
- R3: A toggle in either direction on a masked-in pin of an enabled group sets that group's flag on the third rising clock edge after the pin changes. Group 0 covers pins 7:0, group 1 pins 14:8, group 2 pins 23:16 and group 3 pins 26:24.
- R4: A toggle on a pin whose mask bit is zero, on a pin of a disabled group, or on pin 15 (which belongs to no group) sets no flag.
- R5: The previous-sample register follows every pin on every cycle, so setting a mask bit after that pin has toggled while masked produces no event.
- R6: Request g is high exactly when flag g, group enable g and the global enable are all high. Clearing the group enable drops the request and leaves the flag set.
- R7: Writing the flag register clears each flag whose written bit is one and leaves the others unchanged.
- R8: An acknowledge pulse on group g clears flag g on the next clock edge.
- R9: When a qualifying toggle and a clear of the same flag arrive in the same cycle, the flag is set afterwards.
- R10: A toggle sets only the flag of the pin's own group.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_in | input | 27 | Asynchronous pins; bit 15 belongs to no group |
| gie | input | 1 | Global interrupt enable |
| grp_ack | input | 4 | Per-group acknowledge pulse from the dispatcher |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data for bus_addr, combinational |
| grp_irq | output | 4 | Per-group interrupt request |

## Verification
The bench builds the block with its default two-stage synchronizer and the fixed four-group layout. At this size every one of the 27 pins can be toggled in both directions with all groups open. The bench compares the whole flag register against a one-hot value it computes from the pin number, which catches any slip in the group boundaries, including the gap at pin 15. Single targeted sequences line a toggle up against a clear in the same cycle and exercise unmasking after a masked toggle.

// File: rtl/pcint_pkg.sv
package pcint_pkg;
    localparam int GRP_N  = 4;
    localparam int SLOT_W = 8;
    localparam int PIN_W  = 27;
    localparam int SPAN_W = GRP_N * SLOT_W;

    // Mask bits that have a physical pin behind them.
    function automatic logic [SLOT_W-1:0] grp_valid(input int g);
        case (g)
            1:       grp_valid = 8'h7F;
            3:       grp_valid = 8'h07;
            default: grp_valid = 8'hFF;
        endcase
    endfunction

    typedef struct packed {
        logic [GRP_N-1:0]             ctrl;
        logic [GRP_N-1:0][SLOT_W-1:0] mask;
        logic [GRP_N-1:0]             flag;
    } regs_t;
endpackage

// File: rtl/pcint_sync_edge.sv
module pcint_sync_edge #(
    parameter int WIDTH  = 27,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pin_in,
    output logic [WIDTH-1:0] chg_o
);
    logic [STAGES-1:0][WIDTH-1:0] sr_d, sr_q;
    logic [WIDTH-1:0]             prev_d, prev_q;

    always_comb begin
        sr_d   = {sr_q[STAGES-2:0], pin_in};
        prev_d = sr_q[STAGES-1];
        chg_o  = sr_q[STAGES-1] ^ prev_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr_q   <= '0;
            prev_q <= '0;
        end else begin
            sr_q   <= sr_d;
            prev_q <= prev_d;
        end
    end
endmodule

// File: rtl/pcint_group_hit.sv
module pcint_group_hit #(
    parameter int GRP_N  = 4,
    parameter int SLOT_W = 8
) (
    input  logic [GRP_N*SLOT_W-1:0]      chg_span,
    input  logic [GRP_N-1:0][SLOT_W-1:0] mask,
    input  logic [GRP_N-1:0]             grp_en,
    output logic [GRP_N-1:0]             hit
);
    for (genvar g = 0; g < GRP_N; g++) begin : g_grp
        assign hit[g] = grp_en[g] & (|(chg_span[g*SLOT_W +: SLOT_W] & mask[g]));
    end
endmodule

// File: rtl/pcint_groups.sv
module pcint_groups
    import pcint_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int ADDR_W      = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PIN_W-1:0]  pin_in,
    input  logic              gie,
    input  logic [GRP_N-1:0]  grp_ack,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [SLOT_W-1:0] bus_wdata,
    output logic [SLOT_W-1:0] bus_rdata,
    output logic [GRP_N-1:0]  grp_irq
);
    localparam int CTRL_ADDR = 0;
    localparam int FLAG_ADDR = 1;
    localparam int MASK_BASE = 2;

    regs_t             st_d, st_q;
    logic [PIN_W-1:0]  chg;
    logic [SPAN_W-1:0] chg_span;
    logic [GRP_N-1:0]  hit_vec;
    logic [GRP_N-1:0]  clr;
    logic [GRP_N-1:0]  flag_vec;
    logic [GRP_N-1:0]  ctrl_vec;

    pcint_sync_edge #(.WIDTH(PIN_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_in (pin_in),
        .chg_o  (chg)
    );

    assign chg_span = {{(SPAN_W-PIN_W){1'b0}}, chg};

    pcint_group_hit #(.GRP_N(GRP_N), .SLOT_W(SLOT_W)) u_hit (
        .chg_span (chg_span),
        .mask     (st_q.mask),
        .grp_en   (st_q.ctrl),
        .hit      (hit_vec)
    );

    always_comb begin
        st_d = st_q;
        clr  = grp_ack;
        if (bus_wr && bus_addr == ADDR_W'(CTRL_ADDR))
            st_d.ctrl = bus_wdata[GRP_N-1:0];
        if (bus_wr && bus_addr == ADDR_W'(FLAG_ADDR))
            clr = clr | bus_wdata[GRP_N-1:0];
        for (int g = 0; g < GRP_N; g++) begin
            if (bus_wr && bus_addr == ADDR_W'(MASK_BASE + g))
                st_d.mask[g] = bus_wdata & grp_valid(g);
        end
        // a new toggle outranks a clear in the same cycle
        st_d.flag = (st_q.flag & ~clr) | hit_vec;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(CTRL_ADDR))
            bus_rdata[GRP_N-1:0] = st_q.ctrl;
        if (bus_addr == ADDR_W'(FLAG_ADDR))
            bus_rdata[GRP_N-1:0] = st_q.flag;
        for (int g = 0; g < GRP_N; g++) begin
            if (bus_addr == ADDR_W'(MASK_BASE + g))
                bus_rdata = st_q.mask[g];
        end
    end

    assign grp_irq  = st_q.flag & st_q.ctrl & {GRP_N{gie}};
    assign flag_vec = st_q.flag;
    assign ctrl_vec = st_q.ctrl;
endmodule

// File: rtl/pcint_groups_chk.sv
module pcint_groups_chk
    import pcint_pkg::*;
#(
    parameter int ADDR_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              gie,
    input logic [GRP_N-1:0]  grp_ack,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [SLOT_W-1:0] bus_rdata,
    input logic [GRP_N-1:0]  grp_irq,
    input logic [GRP_N-1:0]  flag,
    input logic [GRP_N-1:0]  ctrl,
    input logic [GRP_N-1:0]  hit
);
    a_r2_ctrl_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == '0) |-> (bus_rdata[SLOT_W-1:GRP_N] == '0));

    for (genvar g = 0; g < GRP_N; g++) begin : g_chk
        a_r3_flag_needs_hit: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(flag[g]) |-> $past(hit[g]));
        a_r6_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
            grp_irq[g] |-> (flag[g] && ctrl[g] && gie));
        a_r8_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
            (grp_ack[g] && !hit[g]) |=> !flag[g]);
        a_r9_set_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
            hit[g] |=> flag[g]);
    end
endmodule

bind pcint_groups pcint_groups_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .gie       (gie),
    .grp_ack   (grp_ack),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata),
    .grp_irq   (grp_irq),
    .flag      (flag_vec),
    .ctrl      (ctrl_vec),
    .hit       (hit_vec)
);

// File: tb/pcint_groups_test.sv
module pcint_groups_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [26:0] pin_in = '0;
    logic        gie = 1'b0;
    logic [3:0]  grp_ack = '0;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic [3:0]  grp_irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    pcint_groups uut (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .gie(gie), .grp_ack(grp_ack),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .grp_irq(grp_irq)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic toggle(input int p);
        @(negedge clk);
        pin_in[p] = ~pin_in[p];
        repeat (4) @(negedge clk);
    endtask

    function automatic logic [7:0] exp_grp(input int p);
        if (p == 15) return 8'h00;
        return 8'h01 << (p / 8);
    endfunction

    initial begin
        logic [7:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        for (int a = 0; a < 6; a++) begin
            rd(3'(a), d);
            chk("R1", d, 8'h00);
        end
        chk("R1 irq", {4'h0, grp_irq}, 8'h00);

        // R2 register map
        wr(3'd0, 8'hFF);
        rd(3'd0, d); chk("R2 ctrl", d, 8'h0F);
        for (int g = 0; g < 4; g++) begin
            int w;
            w = (g == 1) ? 7 : (g == 3) ? 3 : 8;
            wr(3'(2 + g), 8'hFF);
            rd(3'(2 + g), d);
            chk("R2 mask", d, 8'((1 << w) - 1));
        end
        rd(3'd6, d); chk("R2 addr6", d, 8'h00);
        rd(3'd7, d); chk("R2 addr7", d, 8'h00);

        // R3 / R10 / R4(pin 15): sweep each pin, both directions
        for (int p = 0; p < 27; p++) begin
            for (int dir = 0; dir < 2; dir++) begin
                toggle(p);
                rd(3'd1, d);
                chk(p == 15 ? "R4 pin15" : "R3/R10 sweep", d, exp_grp(p));
                wr(3'd1, 8'h0F);
                rd(3'd1, d);
                chk("R7 clear", d, 8'h00);
            end
        end

        // R4 masked pin
        wr(3'd2, 8'hF7);
        toggle(3);
        rd(3'd1, d); chk("R4 masked", d, 8'h00);
        // R5 unmask after masked toggle: no event
        wr(3'd2, 8'hFF);
        repeat (4) @(negedge clk);
        rd(3'd1, d); chk("R5 unmask", d, 8'h00);
        // R4 disabled group
        wr(3'd0, 8'h0E);
        toggle(2);
        rd(3'd1, d); chk("R4 disabled", d, 8'h00);
        wr(3'd0, 8'h0F);

        // R6 request gating
        toggle(18);
        @(negedge clk); chk("R6 gie low", {4'h0, grp_irq}, 8'h00);
        gie = 1'b1;
        @(negedge clk); chk("R6 gie high", {4'h0, grp_irq}, 8'h04);
        wr(3'd0, 8'h0B);
        chk("R6 group off", {4'h0, grp_irq}, 8'h00);
        rd(3'd1, d); chk("R6 flag kept", d, 8'h04);
        wr(3'd0, 8'h0F);

        // R7 write zero has no effect, partial clear
        toggle(9);
        wr(3'd1, 8'h00);
        rd(3'd1, d); chk("R7 zero write", d, 8'h06);
        wr(3'd1, 8'h04);
        rd(3'd1, d); chk("R7 partial", d, 8'h02);

        // R8 acknowledge
        @(negedge clk); grp_ack = 4'b0010;
        @(negedge clk); grp_ack = 4'b0000;
        rd(3'd1, d); chk("R8 ack", d, 8'h00);

        // R9 toggle and write-clear in the same cycle
        toggle(25);
        @(negedge clk); pin_in[25] = ~pin_in[25];
        @(negedge clk);
        @(negedge clk); bus_wr = 1'b1; bus_addr = 3'd1; bus_wdata = 8'h08;
        @(negedge clk); bus_wr = 1'b0;
        rd(3'd1, d); chk("R9 wr vs set", d, 8'h08);
        // R9 toggle and ack in the same cycle
        @(negedge clk); pin_in[25] = ~pin_in[25];
        @(negedge clk);
        @(negedge clk); grp_ack = 4'b1000;
        @(negedge clk); grp_ack = 4'b0000;
        rd(3'd1, d); chk("R9 ack vs set", d, 8'h08);
        chk("R6 irq g3", {4'h0, grp_irq}, 8'h08);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule